// File: doc/BRIEF.md
# Oscillator Start-Up Delay Timer

This block keeps the rest of the chip waiting after the oscillator has been restarted, until its clock can be trusted. It has two triggers. A wake request raised after a low-power sleep starts a short wait that counts oscillator cycles only. Releasing reset starts a longer wait: the same cycle count, then a fixed 14-cycle extension, then a wait measured in ticks of a slow timebase. While either wait runs, the single output `clk_ready` is low. It goes high once the wait is over.

A 3-bit start-up code picks the lengths. Its top bit is a clock-select bit and its two low bits are a start-up field. The code chooses one of three oscillator cycle counts. It also chooses one of three millisecond classes: a short wait for supplies that rise quickly, a long wait for supplies that ramp slowly, or no wait at all for settings meant to be used with brown-out detection enabled. The millisecond waits are given as counts of `ms_tick` pulses, set by parameters. The defaults of 41 and 650 ticks assume a 100 us timebase. The code is latched when a wait begins, so a code that changes during a wait has no effect on it.

Top module: `osc_startup_timer`

## Requirements
- R1: While `rst_n` is low, `clk_ready` is low. The first rising edge of `clk` with `rst_n` high latches `cfg_code` and starts the reset wait, and `clk_ready` stays low after that edge.
- R2: The oscillator cycle count N is set by the code. Codes 000 and 001 give N = 258. Codes 010, 011 and 100 give N = 1024. Codes 101, 110 and 111 give N = 16384.
- R3: A reset wait counts N + 14 cycles. For codes 010 and 101 no tick wait follows, and `clk_ready` first reads high after the (N + 15)-th rising edge, where the edge that latches the code is edge 1.
- R4: After the N + 14 cycles, codes 000, 011 and 110 wait for TICKS_FAST pulses of `ms_tick` (default 41). Codes 001, 100 and 111 wait for TICKS_SLOW pulses (default 650). `clk_ready` rises on the edge that samples the last required pulse.
- R5: `ms_tick` pulses that arrive during the cycle-count part of a reset wait are not counted.
- R6: `wake_req` sampled high on a rising edge while `clk_ready` is high starts a wake wait. `clk_ready` is low after that edge and first reads high after the N-th following edge. A wake wait has no 14-cycle extension and no tick wait.
- R7: `wake_req` is ignored while a wait is in progress.
- R8: `cfg_code` is latched only when a wait starts. Changing it during a wait does not change the length of that wait.
- R9: Asserting `rst_n` during any part of a wait, or while ready, drops `clk_ready` at once. Releasing it starts a complete new reset wait.
- R10: Once high, `clk_ready` stays high until a wake request or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all counting runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; also the reset trigger |
| cfg_code | input | 3 | Start-up code: clock-select bit (MSB) and 2-bit start-up field |
| wake_req | input | 1 | Wake request, sampled while ready |
| ms_tick | input | 1 | Single-cycle pulse from the slow timebase |
| clk_ready | output | 1 | High when the clock is trusted |

## Verification
A fault in the latched code, in the phase or in either counter never corrupts data. It shows only as a change in the edge on which `clk_ready` rises. The bench runs a reference model that tracks that edge exactly, so a shifted boundary is caught on the very cycle where the model and the design disagree. A fault in a 16K-cycle count can therefore take up to about sixteen thousand cycles to appear. Tick handling is exposed by runs with ticks enabled during the cycle phase, where a premature count makes `clk_ready` rise hundreds of cycles early.

// File: rtl/osc_sut_pkg.sv
package osc_sut_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        PH_LOAD  = 2'd0,
        PH_CYC   = 2'd1,
        PH_MS    = 2'd2,
        PH_READY = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        MS_FAST = 2'd0,
        MS_SLOW = 2'd1,
        MS_NONE = 2'd2
    } ms_class_e;

endpackage

// File: rtl/osc_sut_decode.sv
module osc_sut_decode
    import osc_sut_pkg::*;
#(
    parameter int CYC_SHORT  = 258,
    parameter int CYC_MID    = 1024,
    parameter int CYC_LONG   = 16384,
    parameter int EXTRA_RST  = 14,
    parameter int TICKS_FAST = 41,
    parameter int TICKS_SLOW = 650,
    parameter int CNT_W      = 15,
    parameter int TCK_W      = 10
) (
    input  logic [CODE_W-1:0] code,
    input  logic              rst_mode,
    output logic [CNT_W-1:0]  cyc_last,
    output logic [TCK_W-1:0]  tick_last,
    output logic              ms_needed
);

    int        base_cycles;
    int        total_cycles;
    ms_class_e ms_class;

    // Cycle class: low codes short, middle three medium, top three long.
    always_comb begin
        case (code)
            3'd0, 3'd1:       base_cycles = CYC_SHORT;
            3'd2, 3'd3, 3'd4: base_cycles = CYC_MID;
            default:          base_cycles = CYC_LONG;
        endcase
        total_cycles = base_cycles + (rst_mode ? EXTRA_RST : 0);
        cyc_last     = CNT_W'(total_cycles - 1);
    end

    // Millisecond class repeats every three codes: fast, slow, none.
    always_comb begin
        case (code)
            3'd0, 3'd3, 3'd6: ms_class = MS_FAST;
            3'd1, 3'd4, 3'd7: ms_class = MS_SLOW;
            default:          ms_class = MS_NONE;
        endcase
        ms_needed = (ms_class != MS_NONE);
        tick_last = (ms_class == MS_SLOW) ? TCK_W'(TICKS_SLOW - 1)
                                          : TCK_W'(TICKS_FAST - 1);
    end

endmodule

// File: rtl/osc_sut_seq.sv
module osc_sut_seq
    import osc_sut_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int TCK_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              wake_req,
    input  logic              ms_tick,
    input  logic [CNT_W-1:0]  cyc_last,
    input  logic [TCK_W-1:0]  tick_last,
    input  logic              ms_needed,
    output logic [CODE_W-1:0] code_q,
    output logic              rst_mode_q,
    output logic              clk_ready
);

    typedef struct packed {
        phase_e              phase;
        logic [CODE_W-1:0]   code;
        logic                rst_mode;
        logic [CNT_W-1:0]    cnt;
        logic [TCK_W-1:0]    tcnt;
        logic                ready;
    } seq_state_t;

    localparam seq_state_t RESET_STATE = '{
        phase:    PH_LOAD,
        code:     '0,
        rst_mode: 1'b1,
        cnt:      '0,
        tcnt:     '0,
        ready:    1'b0
    };

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_LOAD: begin
                st_d.code     = cfg_code;
                st_d.rst_mode = 1'b1;
                st_d.cnt      = '0;
                st_d.tcnt     = '0;
                st_d.ready    = 1'b0;
                st_d.phase    = PH_CYC;
            end
            PH_CYC: begin
                if (st_q.cnt == cyc_last) begin
                    st_d.cnt = '0;
                    if (st_q.rst_mode && ms_needed) begin
                        st_d.phase = PH_MS;
                    end else begin
                        st_d.phase = PH_READY;
                        st_d.ready = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_MS: begin
                if (ms_tick) begin
                    if (st_q.tcnt == tick_last) begin
                        st_d.phase = PH_READY;
                        st_d.ready = 1'b1;
                    end else begin
                        st_d.tcnt = st_q.tcnt + TCK_W'(1);
                    end
                end
            end
            default: begin
                if (wake_req) begin
                    st_d.code     = cfg_code;
                    st_d.rst_mode = 1'b0;
                    st_d.cnt      = '0;
                    st_d.tcnt     = '0;
                    st_d.ready    = 1'b0;
                    st_d.phase    = PH_CYC;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign code_q     = st_q.code;
    assign rst_mode_q = st_q.rst_mode;
    assign clk_ready  = st_q.ready;

    logic busy;
    assign busy = (st_q.phase == PH_CYC) || (st_q.phase == PH_MS);

    assert_cyc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CYC) |-> (st_q.cnt <= cyc_last));

    assert_no_ms_for_bod_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_MS) |-> (ms_needed && st_q.rst_mode));

    assert_ticks_idle_in_cyc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CYC) |-> (st_q.tcnt == '0));

    assert_wake_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && wake_req) |=> !clk_ready);

    assert_code_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(code_q));

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && !wake_req) |=> clk_ready);

    assert_ready_low_when_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !clk_ready);

endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
    import osc_sut_pkg::*;
#(
    parameter int CYC_SHORT  = 258,
    parameter int CYC_MID    = 1024,
    parameter int CYC_LONG   = 16384,
    parameter int EXTRA_RST  = 14,
    parameter int TICKS_FAST = 41,
    parameter int TICKS_SLOW = 650
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              wake_req,
    input  logic              ms_tick,
    output logic              clk_ready
);

    localparam int CYC_TOP = (CYC_LONG > CYC_MID)
                           ? ((CYC_LONG > CYC_SHORT) ? CYC_LONG : CYC_SHORT)
                           : ((CYC_MID > CYC_SHORT) ? CYC_MID : CYC_SHORT);
    localparam int CYC_MAX = CYC_TOP + EXTRA_RST;
    localparam int TCK_MAX = (TICKS_SLOW > TICKS_FAST) ? TICKS_SLOW : TICKS_FAST;
    localparam int CNT_W   = $clog2(CYC_MAX + 1);
    localparam int TCK_W   = $clog2(TCK_MAX + 1);

    logic [CODE_W-1:0] code_q;
    logic              rst_mode_q;
    logic [CNT_W-1:0]  cyc_last;
    logic [TCK_W-1:0]  tick_last;
    logic              ms_needed;

    osc_sut_decode #(
        .CYC_SHORT (CYC_SHORT),
        .CYC_MID   (CYC_MID),
        .CYC_LONG  (CYC_LONG),
        .EXTRA_RST (EXTRA_RST),
        .TICKS_FAST(TICKS_FAST),
        .TICKS_SLOW(TICKS_SLOW),
        .CNT_W     (CNT_W),
        .TCK_W     (TCK_W)
    ) decode_i (
        .code     (code_q),
        .rst_mode (rst_mode_q),
        .cyc_last (cyc_last),
        .tick_last(tick_last),
        .ms_needed(ms_needed)
    );

    osc_sut_seq #(
        .CNT_W(CNT_W),
        .TCK_W(TCK_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_code  (cfg_code),
        .wake_req  (wake_req),
        .ms_tick   (ms_tick),
        .cyc_last  (cyc_last),
        .tick_last (tick_last),
        .ms_needed (ms_needed),
        .code_q    (code_q),
        .rst_mode_q(rst_mode_q),
        .clk_ready (clk_ready)
    );

endmodule

// File: tb/osc_startup_timer_tb_top.sv
module osc_startup_timer_tb_top;

    localparam int TICK_DIV = 8;
    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_code = 3'b010;
    logic       wake_req = 1'b0;
    logic       ms_tick = 1'b0;
    logic       clk_ready;

    always #5 clk = ~clk;

    osc_startup_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_code (cfg_code),
        .wake_req (wake_req),
        .ms_tick  (ms_tick),
        .clk_ready(clk_ready)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // slow timebase
    bit tick_en = 1'b0;
    int tick_div = 0;
    always @(negedge clk) begin
        if (tick_en) begin
            tick_div = (tick_div + 1) % TICK_DIV;
            ms_tick  = (tick_div == TICK_DIV - 1);
        end else begin
            tick_div = 0;
            ms_tick  = 1'b0;
        end
    end

    // reference model, countdown based
    function automatic int cycles_for(input logic [2:0] c);
        if (c <= 3'd1)      return 258;
        else if (c <= 3'd4) return 1024;
        else                return 16384;
    endfunction

    function automatic int ticks_for(input logic [2:0] c);
        if (c == 3'd0 || c == 3'd3 || c == 3'd6) return 41;
        if (c == 3'd1 || c == 3'd4 || c == 3'd7) return 650;
        return 0;
    endfunction

    int m_phase = 0;   // 0 latch, 1 counting cycles, 2 counting ticks, 3 ready
    int m_cyc_left = 0;
    int m_tick_left = 0;
    bit m_ready = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0;
            m_ready = 1'b0;
        end else begin
            case (m_phase)
                0: begin
                    m_cyc_left  = cycles_for(cfg_code) + 14;
                    m_tick_left = ticks_for(cfg_code);
                    m_phase     = 1;
                end
                1: begin
                    m_cyc_left = m_cyc_left - 1;
                    if (m_cyc_left == 0) begin
                        if (m_tick_left > 0) m_phase = 2;
                        else begin m_phase = 3; m_ready = 1'b1; end
                    end
                end
                2: begin
                    if (ms_tick) begin
                        m_tick_left = m_tick_left - 1;
                        if (m_tick_left == 0) begin m_phase = 3; m_ready = 1'b1; end
                    end
                end
                default: begin
                    if (wake_req) begin
                        m_cyc_left  = cycles_for(cfg_code);
                        m_tick_left = 0;
                        m_phase     = 1;
                        m_ready     = 1'b0;
                    end
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            n_cmp++;
            if (clk_ready !== m_ready) begin
                n_bad++;
                $display("FAIL %s: cycle compare clk_ready=%b expected=%b at %0t",
                         cur_req, clk_ready, m_ready, $time);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT && !finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, WD_LIMIT);
            summary();
        end
    end

    // Count negedges until ready is high. kind: 1 pulse wake, 2 change code, at act_at.
    task automatic run_until_ready(input int act_at, input int kind,
                                   input logic [2:0] val, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (clk_ready === 1'b1 || n > 30000) break;
            #1;
            wake_req = 1'b0;
            if (n == act_at) begin
                if (kind == 1) wake_req = 1'b1;
                if (kind == 2) cfg_code = val;
            end
        end
        #1 wake_req = 1'b0;
    endtask

    task automatic start_reset(input logic [2:0] code);
        @(negedge clk); #1;
        rst_n = 1'b0;
        cfg_code = code;
        @(negedge clk);
        check(clk_ready === 1'b0, "R1 low in reset", clk_ready, 0);
        #1 rst_n = 1'b1;
    endtask

    task automatic start_wake(input logic [2:0] code);
        @(negedge clk); #1;
        cfg_code = code;
        wake_req = 1'b1;
        @(negedge clk);
        check(clk_ready === 1'b0, "R6 drop after wake", clk_ready, 0);
        #1 wake_req = 1'b0;
    endtask

    initial begin
        int n;
        // R1 / R3 / R2: reset with brown-out code 010
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check(clk_ready === 1'b0, "R1 reset state", clk_ready, 0);
        #1 rst_n = 1'b1;
        cur_req = "R3";
        run_until_ready(0, 0, 3'b000, n);
        check(n == 1024 + 15, "R3 code 010 reset length", n, 1024 + 15);

        // R10: holds high
        cur_req = "R10";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(clk_ready === 1'b1, "R10 ready holds", clk_ready, 1);
        end

        // R6 / R2: wake waits
        cur_req = "R6";
        start_wake(3'b000);
        run_until_ready(0, 0, 3'b000, n);
        check(n == 258, "R6 wake code 000", n, 258);
        start_wake(3'b100);
        run_until_ready(0, 0, 3'b000, n);
        check(n == 1024, "R2 wake code 100", n, 1024);
        start_wake(3'b111);
        run_until_ready(0, 0, 3'b000, n);
        check(n == 16384, "R2 wake code 111", n, 16384);

        // R7: wake during a wait is ignored
        cur_req = "R7";
        start_wake(3'b001);
        run_until_ready(100, 1, 3'b000, n);
        check(n == 258, "R7 second wake ignored", n, 258);

        // R8: code change during wake wait ignored
        cur_req = "R8";
        start_wake(3'b001);
        run_until_ready(50, 2, 3'b101, n);
        check(n == 258, "R8 code change during wake", n, 258);

        // R3: long brown-out code on reset
        cur_req = "R3";
        start_reset(3'b101);
        run_until_ready(0, 0, 3'b000, n);
        check(n == 16384 + 15, "R3 code 101 reset length", n, 16384 + 15);

        // R8: code change during reset wait
        cur_req = "R8";
        start_reset(3'b010);
        run_until_ready(10, 2, 3'b111, n);
        check(n == 1039, "R8 code change during reset", n, 1039);

        // R4 / R5: tick waits with ticks running from the start
        cur_req = "R5";
        tick_en = 1'b1;
        start_reset(3'b000);
        run_until_ready(0, 0, 3'b000, n);
        check(n >= 273 + 321 && n <= 273 + 328, "R5 fast ticks after cycles", n, 273 + 324);
        cur_req = "R4";
        start_reset(3'b001);
        run_until_ready(0, 0, 3'b000, n);
        check(n >= 273 + 8 * 649 + 1 && n <= 273 + 8 * 650, "R4 slow ticks", n, 273 + 8 * 650);
        start_reset(3'b110);
        run_until_ready(0, 0, 3'b000, n);
        check(n >= 16399 + 321 && n <= 16399 + 328, "R4 fast ticks long code", n, 16399 + 324);

        // R9: reset in the middle of the cycle phase restarts
        cur_req = "R9";
        start_reset(3'b011);
        repeat (500) @(negedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        check(clk_ready === 1'b0, "R9 low on re-reset", clk_ready, 0);
        #1 rst_n = 1'b1;
        run_until_ready(0, 0, 3'b000, n);
        check(n >= 1039 + 321 && n <= 1039 + 328, "R9 full restart", n, 1039 + 324);
        // reset during tick phase
        start_reset(3'b100);
        repeat (1200) @(negedge clk);
        check(clk_ready === 1'b0, "R9 still waiting in ticks", clk_ready, 0);
        #1 rst_n = 1'b0;
        cfg_code = 3'b010;
        @(negedge clk);
        check(clk_ready === 1'b0, "R9 low on re-reset in ticks", clk_ready, 0);
        #1 rst_n = 1'b1;
        tick_en = 1'b0;
        run_until_ready(0, 0, 3'b000, n);
        check(n == 1039, "R9 restart from tick phase", n, 1039);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule